// File: doc/BRIEF.md
# Dual-Slope PWM Timer Channel

This block is one compare channel of a timer that produces a symmetric (center-aligned) pulse-width waveform. A counter climbs from zero to a ceiling value and then falls back to zero. It advances only on clock cycles where an enable pulse from an outside clock divider is high. One compare value is checked against the counter. The waveform output changes where the counter meets that value. Because both edges of a pulse sit at the same distance from the ceiling, pulse centres do not move when the duty cycle changes.

Software writes the compare value into a holding register. The value reaches the comparator only when the counter is at the ceiling, so a period is never cut short by a write in the middle of it. Four output modes are provided: output held low, toggle on match, normal PWM and inverted PWM. A select input can make the active compare value serve as the ceiling. In toggle mode this gives a square wave with exactly 50% duty. A match flag stays set until software clears it.

Top module: `pwm_dual_slope`

## Requirements
- R1: Counter, direction, active compare value and waveform change only on cycles with `tick` high. With `tick` high every Nth cycle, every period and pulse length is N times its length in ticks.
- R2: The counter steps 0,1,…,C,C-1,…,1,0,1,… where C is the ceiling. The ceiling is `top_val`, or the active compare value when `top_from_cmp` is 1. Each end value is held for one tick, so one period is 2·C ticks.
- R3: In normal mode (`mode`=2) with an active compare value K, 0<K<C, the output is high for 2·K ticks per period. It goes low when the counter reaches K while rising. It goes high when the counter reaches K while falling.
- R4: In normal mode, K=0 keeps the output low for the whole period.
- R5: In normal mode, K≥C keeps the output high for the whole period.
- R6: Inverted mode (`mode`=3) gives the exact complement of the normal-mode output for every K, including K=0 and K=C.
- R7: In toggle mode (`mode`=1) the output inverts on each tick where the counter arrives at K. With `top_from_cmp`=1 this gives a 50% square wave whose period is 4·K ticks.
- R8: In off mode (`mode`=0) the output is driven low on the next tick.
- R9: A write (`cmp_wr` with `cmp_wdata`) goes to a holding register. The active compare value loads from that register only on a tick where the counter equals the ceiling.
- R10: `match_flag` goes high in the cycle after a tick on which the counter equals the active compare value. It then stays high until a cycle with `flag_clr` high. If a set and a clear fall in the same cycle, the flag stays set.
- R11: While `rst_n` is low, the waveform and the flag are 0. The counter is 0 and counting up, and both compare registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the outside divider |
| top_val | input | W | Ceiling value when `top_from_cmp` is 0 |
| top_from_cmp | input | 1 | Use the active compare value as the ceiling |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_wdata | input | W | Compare value to write |
| mode | input | 2 | 0 off, 1 toggle, 2 normal PWM, 3 inverted PWM |
| flag_clr | input | 1 | Clear the match flag |
| wave_out | output | 1 | PWM waveform |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
High time is measured over a window one period long at three kinds of compare value: zero, mid-range and equal to the ceiling. A zero or ceiling value that is not forced would give one stray tick high or low. Each pattern runs in both polarities and with tick divisors of 1 and 8. A change of ceiling shows whether the period follows the ceiling rather than a fixed count. A compare write made just after a falling edge separates buffered loading from immediate loading by the length of the next low run. Clearing the flag on the same cycle as a match shows which of the two wins.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    PDS_OFF    = 2'd0,
    PDS_TOGGLE = 2'd1,
    PDS_NONINV = 2'd2,
    PDS_INV    = 2'd3
  } pds_mode_e;
endpackage

// File: rtl/pds_counter.sv
module pds_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top_eff,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_n,
  output logic         dir_n
);
  localparam logic [W-1:0] ONE = W'(1);

  logic         dir_q;
  logic [W-1:0] step_cnt;
  logic         step_up;

  // next count: reverse at the ceiling, bounce at zero
  always_comb begin
    if (cnt_q >= top_eff) begin
      step_up  = 1'b0;
      step_cnt = (cnt_q == '0) ? '0 : cnt_q - ONE;
    end else if (cnt_q == '0) begin
      step_up  = 1'b1;
      step_cnt = ONE;
    end else if (dir_q) begin
      step_up  = 1'b1;
      step_cnt = cnt_q + ONE;
    end else begin
      step_up  = 1'b0;
      step_cnt = cnt_q - ONE;
    end
    cnt_n = tick ? step_cnt : cnt_q;
    dir_n = tick ? step_up  : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end
endmodule

// File: rtl/pds_compare.sv
module pds_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] top_eff,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] ocr_q,
  output logic [W-1:0] ocr_n,
  output logic         flag_q
);
  logic [W-1:0] hold_q, hold_n;
  logic         flag_n;
  logic         load, hit;

  always_comb begin
    load   = tick && (cnt_q == top_eff);
    hit    = tick && (cnt_q == ocr_q);
    hold_n = wr ? wdata : hold_q;
    ocr_n  = load ? hold_q : ocr_q;
    // a set in the same cycle as a clear wins
    if (hit)      flag_n = 1'b1;
    else if (clr) flag_n = 1'b0;
    else          flag_n = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ocr_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      hold_q <= hold_n;
      ocr_q  <= ocr_n;
      flag_q <= flag_n;
    end
  end
endmodule

// File: rtl/pds_wave.sv
module pds_wave
  import pds_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  pds_mode_e    mode,
  input  logic [W-1:0] cnt_n,
  input  logic         dir_n,
  input  logic [W-1:0] ocr_n,
  input  logic [W-1:0] top_n,
  output logic         wave_q
);
  logic lvl, sel, wave_n;

  always_comb begin
    // level of the normal waveform at the count being entered
    if (ocr_n == '0)        lvl = 1'b0;
    else if (ocr_n >= top_n) lvl = 1'b1;
    else if (dir_n)          lvl = (cnt_n <  ocr_n);
    else                     lvl = (cnt_n <= ocr_n);

    unique case (mode)
      PDS_OFF:    sel = 1'b0;
      PDS_TOGGLE: sel = wave_q ^ (cnt_n == ocr_n);
      PDS_NONINV: sel = lvl;
      PDS_INV:    sel = ~lvl;
      default:    sel = 1'b0;
    endcase
    wave_n = tick ? sel : wave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_n;
  end
endmodule

// File: rtl/pwm_dual_slope.sv
module pwm_dual_slope
  import pds_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] top_val,
  input  logic         top_from_cmp,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic [1:0]   mode,
  input  logic         flag_clr,
  output logic         wave_out,
  output logic         match_flag
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         dir_n;
  logic [W-1:0] ocr_q, ocr_n;
  logic [W-1:0] top_eff, top_n;

  assign top_eff = top_from_cmp ? ocr_q : top_val;
  assign top_n   = top_from_cmp ? ocr_n : top_val;

  pds_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_eff(top_eff),
    .cnt_q(cnt_q), .cnt_n(cnt_n), .dir_n(dir_n)
  );

  pds_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .top_eff(top_eff),
    .wr(cmp_wr), .wdata(cmp_wdata), .clr(flag_clr),
    .ocr_q(ocr_q), .ocr_n(ocr_n), .flag_q(match_flag)
  );

  pds_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(pds_mode_e'(mode)),
    .cnt_n(cnt_n), .dir_n(dir_n), .ocr_n(ocr_n), .top_n(top_n),
    .wave_q(wave_out)
  );
endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         flag_clr,
  input logic [1:0]   mode,
  input logic         wave_out,
  input logic         match_flag,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top_eff,
  input logic [W-1:0] ocr
);
  a_r1_wave_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(wave_out));

  a_r1_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd0) |=> !wave_out);

  a_r9_load_only_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && cnt == top_eff) |=> $stable(ocr));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);

  a_r10_flag_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(match_flag));
endmodule

bind pwm_dual_slope pds_checker #(.W(W)) u_pds_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .flag_clr(flag_clr), .mode(mode),
  .wave_out(wave_out), .match_flag(match_flag), .cnt(cnt_q),
  .top_eff(top_eff), .ocr(ocr_q)
);

// File: tb/test_pwm_dual_slope.sv
`timescale 1ns/1ps
module test_pwm_dual_slope;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick;
  logic [W-1:0] top_val;
  logic         top_from_cmp;
  logic         cmp_wr;
  logic [W-1:0] cmp_wdata;
  logic [1:0]   mode;
  logic         flag_clr;
  logic         wave_out;
  logic         match_flag;

  int total = 0;
  int bad   = 0;
  int presc = 1;
  int pc    = 0;
  bit hold  = 1'b0;
  bit meas_req = 1'b0;

  typedef struct {
    int    win;
    int    hi;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  pwm_dual_slope #(.W(W)) i_pwm_dual_slope (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val),
    .top_from_cmp(top_from_cmp), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .mode(mode), .flag_clr(flag_clr), .wave_out(wave_out),
    .match_flag(match_flag)
  );

  // tick source: one enable every presc cycles
  always @(negedge clk) begin
    tick = !hold && (pc == 0);
    pc   = (pc + 1 >= presc) ? 0 : pc + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops an expected item and measures one window of high time
  initial begin
    forever begin
      exp_t it;
      int   hc;
      wait (meas_req == 1'b1);
      it = sb.pop_front();
      hc = 0;
      repeat (it.win) begin
        @(negedge clk);
        if (wave_out) hc++;
      end
      chk(hc == it.hi, it.tag, hc, it.hi);
      meas_req = 1'b0;
    end
  end

  task automatic write_cmp(input int v);
    @(negedge clk);
    cmp_wr = 1'b1; cmp_wdata = W'(v);
    @(negedge clk);
    cmp_wr = 1'b0;
  endtask

  // driver: configure, settle, push expectation computed from the requirements
  task automatic run_duty(input string tag, input int md, input int top, input bit fc,
                          input int k, input int p);
    exp_t it;
    int   ceil_v, win, hi;
    @(negedge clk);
    presc = p; mode = 2'(md); top_val = W'(top); top_from_cmp = fc;
    write_cmp(k);
    ceil_v = fc ? k : top;
    win    = (md == 1) ? 4 * ceil_v * p : 2 * ceil_v * p;
    case (md)
      0: hi = 0;
      1: hi = win / 2;
      2: hi = (k == 0) ? 0 : (k >= ceil_v) ? win : 2 * k * p;
      default: hi = (k == 0) ? win : (k >= ceil_v) ? 0 : win - 2 * k * p;
    endcase
    repeat (4 * win + 40) @(negedge clk);
    it.win = win; it.hi = hi; it.tag = tag;
    sb.push_back(it);
    meas_req = 1'b1;
    wait (meas_req == 1'b0);
  endtask

  task automatic wait_fall();
    logic p;
    @(negedge clk);
    p = wave_out;
    forever begin
      @(negedge clk);
      if (p && !wave_out) break;
      p = wave_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic w0, f0;
    int   n;
    rst_n = 1'b0; top_val = 8'd10; top_from_cmp = 1'b0; cmp_wr = 1'b0;
    cmp_wdata = '0; mode = 2'd2; flag_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk(wave_out == 1'b0, "R11 wave in reset", wave_out, 0);
    chk(match_flag == 1'b0, "R11 flag in reset", match_flag, 0);
    rst_n = 1'b1;

    run_duty("R3 normal K=3 C=10 div1", 2, 10, 0, 3, 1);
    run_duty("R1 normal K=3 C=10 div8", 2, 10, 0, 3, 8);
    run_duty("R4 normal K=0 div1", 2, 10, 0, 0, 1);
    run_duty("R4 normal K=0 div8", 2, 10, 0, 0, 8);
    run_duty("R5 normal K=C div1", 2, 10, 0, 10, 1);
    run_duty("R5 normal K=C div8", 2, 10, 0, 10, 8);
    run_duty("R6 inverted K=3 div1", 3, 10, 0, 3, 1);
    run_duty("R6 inverted K=3 div8", 3, 10, 0, 3, 8);
    run_duty("R6 inverted K=0", 3, 10, 0, 0, 1);
    run_duty("R6 inverted K=C", 3, 10, 0, 10, 1);
    run_duty("R2 normal K=2 C=5", 2, 5, 0, 2, 1);
    run_duty("R7 toggle ceiling=K=6 div1", 1, 10, 1, 6, 1);
    run_duty("R7 toggle ceiling=K=6 div8", 1, 10, 1, 6, 8);
    run_duty("R8 off", 0, 10, 0, 3, 1);

    // R1: no ticks, nothing moves
    run_duty("R3 normal K=4 C=10", 2, 10, 0, 4, 1);
    @(negedge clk); hold = 1'b1;
    @(negedge clk); w0 = wave_out; f0 = match_flag;
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (wave_out != w0 || match_flag != f0) n++;
    end
    chk(n == 0, "R1 frozen without tick", n, 0);
    hold = 1'b0;

    // R10: clear on a match cycle keeps the flag, clear later drops it
    run_duty("R3 normal K=3 again", 2, 10, 0, 3, 1);
    wait_fall();
    flag_clr = 1'b1;
    @(negedge clk);
    chk(match_flag == 1'b1, "R10 set beats clear", match_flag, 1);
    @(negedge clk);
    chk(match_flag == 1'b0, "R10 clear", match_flag, 0);
    flag_clr = 1'b0;
    repeat (25) @(negedge clk);
    chk(match_flag == 1'b1, "R10 set on next match and held", match_flag, 1);

    // R9: write just after a falling edge; new value only after the ceiling
    wait_fall();
    cmp_wr = 1'b1; cmp_wdata = 8'd7;
    n = 1;
    forever begin
      @(negedge clk);
      cmp_wr = 1'b0;
      if (!wave_out) n++;
      else break;
    end
    chk(n == 10, "R9 low run after buffered write", n, 10);
    begin
      exp_t it;
      it.win = 20; it.hi = 14; it.tag = "R9 new duty after load";
      sb.push_back(it);
      meas_req = 1'b1;
      wait (meas_req == 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule